// File: doc/BRIEF.md
# Indexed Register Remap Table

This block is one pipeline stage placed after instruction expansion and before register rename in an in-order core. Register numbers are 7 bits wide. The upper half of the register space, where bit 6 is set, can be addressed indirectly. A per-register latch supplies the real location inside that half. When an operand names an upper-half register, the stage replaces its low six bits with the 6-bit address held in the matching entry of a 64-entry table.

Each entry also has a ready flag. An instruction that will rewrite an index clears the flag when it issues. A later writeback delivers the new address and sets the flag again. An instruction whose indexed operand depends on a cleared flag is held in the stage, with the stall output raised, until the writeback lands. A global enable input turns the mechanism off. While it is low, every operand goes through untouched and the stage never stalls, so code that knows nothing of indexing runs as before.

Top module: `idx_remap_table`

## Requirements
- R1: With the enable high, an operand whose bit 6 is set leaves as {1'b1, A}, where A is the 6-bit address held in the table entry selected by the operand's bits 5:0.
- R2: Each of the 64 entries has a ready flag. An indexed operand whose entry is not ready raises stall.
- R3: An operand with bit 6 clear leaves unchanged and never causes a stall, whatever the table holds.
- R4: With the enable low, both operands leave unchanged and stall stays low, even for entries that are not ready.
- R5: The stall is the OR of both operands' not-ready conditions. While stall is high, out_vld is low, the held instruction keeps its operands, and new input is not taken.
- R6: A writeback loads the 6-bit address into its entry and sets that entry's ready flag at the clock edge. A stalled instruction leaves with the new address after that edge.
- R7: An instruction accepted at a clock edge (in_vld high, stall low) appears on the outputs right after that edge and stays valid for exactly one cycle if nothing follows it.
- R8: An issue notification clears the named entry's ready flag at the next edge. If an issue and a writeback name the same entry in the same cycle, the entry ends not ready and still takes the written address.
- R9: After reset, all entries are ready, each entry holds its own index, and out_vld and stall are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_en | input | 1 | Global enable for indexed remapping |
| in_vld | input | 1 | Instruction present from expand |
| src_a | input | 7 | First source register number |
| src_b | input | 7 | Second source register number |
| issue_vld | input | 1 | An instruction writing an index register issued |
| issue_idx | input | 6 | Table entry that issue will rewrite |
| wb_vld | input | 1 | Index update arriving |
| wb_idx | input | 6 | Table entry being updated |
| wb_addr | input | 6 | New real address for that entry |
| out_vld | output | 1 | Remapped instruction valid toward rename |
| out_a | output | 7 | First operand after remapping |
| out_b | output | 7 | Second operand after remapping |
| stall | output | 1 | Held instruction waits on a pending index |

## Verification
The bench sweeps every 7-bit operand value on both operand positions in three conditions: the identity table after reset, a scrambled table written by writebacks, and the enable low. A design that remapped lower-half operands, or ignored the enable, fails these sweeps at once. Every entry is made pending in turn from either operand position, then released by a writeback. This catches stalls charged to the wrong operand, a release that keeps the stale address, and an instruction lost or duplicated around the stall. It also covers an issue and a writeback to the same entry in one cycle, where a wrong priority would let the instruction through early, and a pending entry reached through a lower-half operand or with the enable low, where a design that stalls wrongly would freeze.

// File: rtl/idx_remap_pkg.sv
package idx_remap_pkg;

  // Classification of one source operand in the remap stage.
  typedef enum logic [1:0] {
    OP_DIRECT        = 2'd0,
    OP_INDEXED_READY = 2'd1,
    OP_INDEXED_WAIT  = 2'd2
  } opnd_class_e;

  localparam int unsigned DEF_ENTRIES = 64;

endpackage

// File: rtl/remap_entry_bank.sv
module remap_entry_bank #(
  parameter  int unsigned N_ENT = 64,
  localparam int unsigned IW    = $clog2(N_ENT)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      issue_vld,
  input  logic [IW-1:0]             issue_idx,
  input  logic                      wb_vld,
  input  logic [IW-1:0]             wb_idx,
  input  logic [IW-1:0]             wb_addr,
  output logic [N_ENT-1:0][IW-1:0]  addr_tab,
  output logic [N_ENT-1:0]          rdy_vec
);

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic          wb_hit;
    logic          iss_hit;
    logic          ent_en;
    logic [IW-1:0] addr_d;
    logic [IW-1:0] addr_q;
    logic          rdy_d;
    logic          rdy_q;

    assign wb_hit  = wb_vld    && (wb_idx    == IW'(i));
    assign iss_hit = issue_vld && (issue_idx == IW'(i));
    assign ent_en  = wb_hit | iss_hit;

    // Next state: a pending issue outranks a completing writeback.
    always_comb begin
      addr_d = addr_q;
      rdy_d  = rdy_q;
      if (wb_hit) begin
        addr_d = wb_addr;
        rdy_d  = 1'b1;
      end
      if (iss_hit) begin
        rdy_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q <= IW'(i);
        rdy_q  <= 1'b1;
      end else if (ent_en) begin
        addr_q <= addr_d;
        rdy_q  <= rdy_d;
      end
    end

    assign addr_tab[i] = addr_q;
    assign rdy_vec[i]  = rdy_q;
  end

endmodule

// File: rtl/remap_lookup.sv
module remap_lookup
  import idx_remap_pkg::*;
#(
  parameter  int unsigned N_ENT = 64,
  localparam int unsigned IW    = $clog2(N_ENT),
  localparam int unsigned OW    = IW + 1
) (
  input  logic                      idx_en,
  input  logic [OW-1:0]             opnd_i,
  input  logic [N_ENT-1:0][IW-1:0]  addr_tab,
  input  logic [N_ENT-1:0]          rdy_vec,
  output logic [OW-1:0]             opnd_o,
  output logic                      wait_o
);

  opnd_class_e   cls;
  logic [IW-1:0] idx;

  assign idx = opnd_i[IW-1:0];

  always_comb begin
    if (!idx_en || !opnd_i[OW-1]) begin
      cls = OP_DIRECT;
    end else if (rdy_vec[idx]) begin
      cls = OP_INDEXED_READY;
    end else begin
      cls = OP_INDEXED_WAIT;
    end
  end

  always_comb begin
    unique case (cls)
      OP_DIRECT: opnd_o = opnd_i;
      default:   opnd_o = {1'b1, addr_tab[idx]};
    endcase
  end

  assign wait_o = (cls == OP_INDEXED_WAIT);

endmodule

// File: rtl/remap_stage.sv
module remap_stage #(
  parameter int unsigned OW   = 7,
  parameter int unsigned NSRC = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      adv,
  input  logic                      in_vld,
  input  logic [NSRC-1:0][OW-1:0]   in_opnd,
  output logic                      st_vld,
  output logic [NSRC-1:0][OW-1:0]   st_opnd
);

  logic                    vld_d;
  logic                    opnd_en;
  logic [NSRC-1:0][OW-1:0] opnd_d;

  always_comb begin
    vld_d   = in_vld;
    opnd_en = adv & in_vld;
    opnd_d  = in_opnd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_vld <= 1'b0;
    end else if (adv) begin
      st_vld <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_opnd <= '0;
    end else if (opnd_en) begin
      st_opnd <= opnd_d;
    end
  end

endmodule

// File: rtl/idx_remap_table.sv
module idx_remap_table #(
  parameter  int unsigned N_ENT = 64,
  localparam int unsigned IW    = $clog2(N_ENT),
  localparam int unsigned OW    = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_en,
  input  logic          in_vld,
  input  logic [OW-1:0] src_a,
  input  logic [OW-1:0] src_b,
  input  logic          issue_vld,
  input  logic [IW-1:0] issue_idx,
  input  logic          wb_vld,
  input  logic [IW-1:0] wb_idx,
  input  logic [IW-1:0] wb_addr,
  output logic          out_vld,
  output logic [OW-1:0] out_a,
  output logic [OW-1:0] out_b,
  output logic          stall
);

  localparam int unsigned NSRC = 2;

  logic [NSRC-1:0][OW-1:0]  src_vec;
  logic [NSRC-1:0][OW-1:0]  st_opnd;
  logic [NSRC-1:0][OW-1:0]  map_opnd;
  logic [NSRC-1:0]          wait_vec;
  logic                     st_vld;
  logic                     adv;
  logic [N_ENT-1:0][IW-1:0] addr_tab;
  logic [N_ENT-1:0]         rdy_vec;

  assign src_vec = {src_b, src_a};
  assign adv     = ~stall;

  remap_stage #(
    .OW   (OW),
    .NSRC (NSRC)
  ) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .in_vld  (in_vld),
    .in_opnd (src_vec),
    .st_vld  (st_vld),
    .st_opnd (st_opnd)
  );

  remap_entry_bank #(
    .N_ENT (N_ENT)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue_vld (issue_vld),
    .issue_idx (issue_idx),
    .wb_vld    (wb_vld),
    .wb_idx    (wb_idx),
    .wb_addr   (wb_addr),
    .addr_tab  (addr_tab),
    .rdy_vec   (rdy_vec)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    remap_lookup #(
      .N_ENT (N_ENT)
    ) u_lookup (
      .idx_en   (idx_en),
      .opnd_i   (st_opnd[s]),
      .addr_tab (addr_tab),
      .rdy_vec  (rdy_vec),
      .opnd_o   (map_opnd[s]),
      .wait_o   (wait_vec[s])
    );
  end

  assign stall   = st_vld & (|wait_vec);
  assign out_vld = st_vld & ~stall;
  assign out_a   = map_opnd[0];
  assign out_b   = map_opnd[1];

endmodule

// File: rtl/idx_remap_table_chk.sv
module idx_remap_table_chk #(
  parameter  int unsigned N_ENT = 64,
  localparam int unsigned IW    = $clog2(N_ENT),
  localparam int unsigned OW    = IW + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             idx_en,
  input logic             in_vld,
  input logic             issue_vld,
  input logic [IW-1:0]    issue_idx,
  input logic             wb_vld,
  input logic [IW-1:0]    wb_idx,
  input logic             out_vld,
  input logic [OW-1:0]    out_a,
  input logic [OW-1:0]    out_b,
  input logic             stall,
  input logic             st_vld,
  input logic [OW-1:0]    st_a,
  input logic [OW-1:0]    st_b,
  input logic [N_ENT-1:0] rdy_vec
);

  // R1
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && idx_en && st_a[OW-1]) |-> out_a[OW-1]);

  // R2
  wait_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_vld && idx_en && st_a[OW-1] && !rdy_vec[st_a[IW-1:0]]) |-> stall);

  // R3
  direct_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !st_a[OW-1] && !st_b[OW-1]) |-> (out_a == st_a && out_b == st_b));

  // R4
  bypass_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_en |-> !stall);

  // R4
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !idx_en) |-> (out_a == st_a && out_b == st_b));

  // R5
  stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !out_vld);

  // R5
  stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(st_a) && $stable(st_b) && st_vld));

  // R6
  wb_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_vld && !(issue_vld && issue_idx == wb_idx)) |=> rdy_vec[$past(wb_idx)]);

  // R7
  accept_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !stall) |=> (out_vld || stall));

  // R8
  issue_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |=> !rdy_vec[$past(issue_idx)]);

endmodule

bind idx_remap_table idx_remap_table_chk #(
  .N_ENT (N_ENT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .idx_en    (idx_en),
  .in_vld    (in_vld),
  .issue_vld (issue_vld),
  .issue_idx (issue_idx),
  .wb_vld    (wb_vld),
  .wb_idx    (wb_idx),
  .out_vld   (out_vld),
  .out_a     (out_a),
  .out_b     (out_b),
  .stall     (stall),
  .st_vld    (st_vld),
  .st_a      (st_opnd[0]),
  .st_b      (st_opnd[1]),
  .rdy_vec   (rdy_vec)
);

// File: tb/idx_remap_table_bench.sv
module idx_remap_table_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 64;

  logic       clk;
  logic       rst_n;
  logic       idx_en;
  logic       in_vld;
  logic [6:0] src_a;
  logic [6:0] src_b;
  logic       issue_vld;
  logic [5:0] issue_idx;
  logic       wb_vld;
  logic [5:0] wb_idx;
  logic [5:0] wb_addr;
  logic       out_vld;
  logic [6:0] out_a;
  logic [6:0] out_b;
  logic       stall;

  int checks;
  int errors;
  int ref_addr [N];
  bit ref_rdy  [N];
  bit en_ref;

  idx_remap_table u_idx_remap_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_en    (idx_en),
    .in_vld    (in_vld),
    .src_a     (src_a),
    .src_b     (src_b),
    .issue_vld (issue_vld),
    .issue_idx (issue_idx),
    .wb_vld    (wb_vld),
    .wb_idx    (wb_idx),
    .wb_addr   (wb_addr),
    .out_vld   (out_vld),
    .out_a     (out_a),
    .out_b     (out_b),
    .stall     (stall)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_map(input int op);
    if (en_ref && op >= 64) return 64 + ref_addr[op-64];
    return op;
  endfunction

  function automatic bit exp_stall(input int a, input int b);
    bit wa = en_ref && a >= 64 && !ref_rdy[a-64];
    bit wb = en_ref && b >= 64 && !ref_rdy[b-64];
    return wa || wb;
  endfunction

  task automatic set_en(input bit e);
    @(negedge clk);
    idx_en = e;
    en_ref = e;
  endtask

  // One table update cycle; the bench model follows R6/R8 priority.
  task automatic upd(input bit iv, input int ii, input bit wv, input int wi, input int wa);
    @(negedge clk);
    issue_vld = iv; issue_idx = 6'(ii);
    wb_vld = wv; wb_idx = 6'(wi); wb_addr = 6'(wa);
    @(negedge clk);
    issue_vld = 1'b0; wb_vld = 1'b0;
    if (wv) begin ref_addr[wi] = wa; ref_rdy[wi] = 1'b1; end
    if (iv) ref_rdy[ii] = 1'b0;
  endtask

  task automatic present(input int a, input int b);
    @(negedge clk);
    in_vld = 1'b1; src_a = 7'(a); src_b = 7'(b);
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  task automatic expect_out(input string req, input int a, input int b);
    bit st = exp_stall(a, b);
    check({req, " stall"}, int'(stall), int'(st));
    check({req, " out_vld"}, int'(out_vld), int'(!st));
    if (!st) begin
      check({req, " out_a"}, int'(out_a), exp_map(a));
      check({req, " out_b"}, int'(out_b), exp_map(b));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    rst_n = 1'b0; idx_en = 1'b1; en_ref = 1'b1; in_vld = 1'b0;
    src_a = '0; src_b = '0; issue_vld = 1'b0; issue_idx = '0;
    wb_vld = 1'b0; wb_idx = '0; wb_addr = '0;
    for (int i = 0; i < N; i++) begin ref_addr[i] = i; ref_rdy[i] = 1'b1; end
    repeat (3) @(negedge clk);
    // R9 outputs idle during reset
    check("R9 reset out_vld", int'(out_vld), 0);
    check("R9 reset stall", int'(stall), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle out_vld", int'(out_vld), 0);

    // R9 identity map and R1/R3 over all operand values
    for (int a = 0; a < 128; a++) begin
      present(a, 127 - a);
      expect_out("R9 R1 R3 identity", a, 127 - a);
    end
    // R7 single-cycle output after a lone instruction
    present(70, 3);
    check("R7 valid after accept", int'(out_vld), 1);
    @(negedge clk);
    check("R7 one cycle only", int'(out_vld), 0);

    // R6 program a scrambled table, then R1 sweep
    for (int i = 0; i < N; i++) upd(1'b0, 0, 1'b1, i, (i * 37 + 5) % 64);
    for (int a = 0; a < 128; a++) begin
      present(a, a ^ 7'h41);
      expect_out("R1 scrambled", a, a ^ 7'h41);
    end

    // R4 bypass sweep
    set_en(1'b0);
    for (int a = 0; a < 128; a++) begin
      present(a, (a + 64) % 128);
      expect_out("R4 bypass", a, (a + 64) % 128);
    end
    set_en(1'b1);

    // R2 R5 R6: each entry pending through operand a, then b
    for (int k = 0; k < N; k++) begin
      upd(1'b1, k, 1'b0, 0, 0);
      present(64 + k, 3);
      expect_out("R2 R5 pending a", 64 + k, 3);
      @(negedge clk);
      check("R5 still stalled", int'(stall), 1);
      upd(1'b0, 0, 1'b1, k, 63 - k);
      expect_out("R6 resume a", 64 + k, 3);
      @(negedge clk);
      check("R7 no duplicate", int'(out_vld), 0);

      upd(1'b1, k, 1'b0, 0, 0);
      present(5, 64 + k);
      expect_out("R5 pending b", 5, 64 + k);
      upd(1'b0, 0, 1'b1, k, (k * 11) % 64);
      expect_out("R6 resume b", 5, 64 + k);
    end

    // R8 issue and writeback to the same entry in one cycle
    upd(1'b1, 33, 1'b1, 33, 9);
    present(64 + 33, 1);
    expect_out("R8 issue wins", 64 + 33, 1);
    upd(1'b0, 0, 1'b1, 33, 12);
    expect_out("R8 resolve", 64 + 33, 1);

    // R3 lower-half operand with a pending entry of the same index
    upd(1'b1, 20, 1'b0, 0, 0);
    present(20, 21);
    expect_out("R3 direct no stall", 20, 21);
    // R4 pending entry ignored while disabled
    set_en(1'b0);
    present(84, 84);
    expect_out("R4 pending bypassed", 84, 84);
    set_en(1'b1);
    upd(1'b0, 0, 1'b1, 20, 44);
    present(84, 20);
    expect_out("R6 entry after release", 84, 20);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule